// File: doc/BRIEF.md
# Serial Converter Interface Sequencer

This block is the digital side of a serial-controlled 10-bit converter. A host drives an active-low select, a serial clock and a serial address line. While a transfer runs, the block does three things. It takes in a 4-bit channel code for the next conversion. It shifts out the result of the conversion before, most significant bit first. It also marks the interval in which the selected input is being sampled. Once enough serial clocks have arrived, it starts a conversion and holds the end-of-conversion flag low until the new result is ready.

All three host inputs are asynchronous to the block's system clock. Each one passes through a synchronizer chain, and the serial clock edges are detected in the system clock domain. The conversion is modelled as a cycle counter of fixed length. When it ends, the result is taken from a parallel data input that the environment drives according to the channel being converted. Channel codes above the last valid channel give an all-zero result.

The select line can be used in two ways. It can be released between transfers, in which case its falling edge presents the previous result. It can also be held low, in which case either the end of the conversion or the sixteenth serial clock presents the new result, depending on whether the conversion finished before or after the transfer did.

Top module: `adc_serial_seq`

## Requirements
- R1: While the synchronized select is high, `sdo_en` is 0. Serial clock and address activity changes neither the channel code nor `eoc`, and starts no conversion.
- R2: A falling select edge clears the bit counters, sets `sdo_en` to 1 and places bit 9 of the stored result on `sdo`.
- R3: The channel code is assembled from `addr_sdi` on the first four rising serial clock edges, first bit received as bit 3. Later rising edges leave it unchanged, and `conv_chan` shows it once a conversion starts.
- R4: Each of falling serial clock edges 1 to 9 moves `sdo` one bit down the stored result, so bit 0 is on `sdo` after the ninth falling edge.
- R5: From the tenth falling serial clock edge until the next reload, `sdo` is 0, however many extra clocks follow.
- R6: `sample_win` is 1 from the fourth falling serial clock edge until the tenth, and 0 outside that interval.
- R7: The tenth falling edge starts a conversion. `eoc` is then 0 for exactly `CONV_CYC` system clock cycles, after which the stored result equals `conv_data`. `eoc` is 1 after reset.
- R8: A channel code greater than `LAST_CH` (13) stores an all-zero result.
- R9: With select held low, if the conversion ends after exactly 10 rising and 10 falling edges, or after 16 falling edges, the block reloads at once. The counters clear and bit 9 of the new result appears on `sdo` without any select edge.
- R10: With select held low, if the conversion ends after at least 11 rising edges but fewer than 16 falling edges, `sdo` stays 0 until the sixteenth falling edge. That edge reloads the block and presents bit 9 of the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host, asynchronous |
| io_clk | input | 1 | Serial clock from the host, asynchronous |
| addr_sdi | input | 1 | Serial channel code, asynchronous |
| conv_data | input | RES_W | Result value for the channel on `conv_chan` |
| sdo | output | 1 | Serial result data |
| sdo_en | output | 1 | Output enable for `sdo` (0 means high impedance) |
| eoc | output | 1 | End of conversion, low while converting |
| sample_win | output | 1 | High while the selected input is being sampled |
| conv_chan | output | ADDR_W | Channel code of the current or last conversion |

## Verification
The assertions check the following on every cycle. The channel code stays frozen while select is high and after the fourth address bit. Every drop of `eoc` and every rise of `sample_win` follows a detected serial clock edge. `sdo` is zero in the tail of a transfer. Every reload presents the stored MSB. Only the bench scenarios can show the end-to-end orderings: the bit order across a whole transfer, the exact length of the conversion, the zero result for an out-of-range channel, and which event presents the next MSB under each way of using select. That last point means an immediate reload for 10-clock and fast 16-clock transfers with select held low, and a reload deferred to the sixteenth clock in slow transfers.

// File: rtl/adc_serial_seq_pkg.sv
package adc_serial_seq_pkg;
   localparam int unsigned ADDR_W    = 4;
   localparam int unsigned CNT_W     = 5;
   localparam int unsigned ADDR_BITS = 4;
   localparam int unsigned SAMP_BEG  = 4;
   localparam int unsigned HOLD_EDGE = 10;
   localparam int unsigned LONG_XFER = 16;

   typedef logic [CNT_W-1:0] edge_cnt_t;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] lvl_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("adc_seq_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], async_i[g]};
      end
      assign lvl_o[g] = chain[STAGES-1];
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_serial_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_lvl_i,
   input  logic              sclk_lvl_i,
   input  logic              sdat_i,
   input  logic              done_i,
   output logic              active_o,
   output logic              sclk_fall_o,
   output logic              load_o,
   output logic              start_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              sample_win_o,
   output logic              tail_zero_o
);
   localparam edge_cnt_t ADDR_LAST = edge_cnt_t'(ADDR_BITS);
   localparam edge_cnt_t SAMP_LO   = edge_cnt_t'(SAMP_BEG);
   localparam edge_cnt_t HOLD_N    = edge_cnt_t'(HOLD_EDGE);
   localparam edge_cnt_t LONG_N    = edge_cnt_t'(LONG_XFER);

   logic cs_prev, sclk_prev;
   logic active, cs_fall, sclk_rise, sclk_fall;
   edge_cnt_t rise_cnt, fall_cnt;
   logic [ADDR_W-1:0] addr_sh;
   logic pend_q;
   logic reload_now, reload_late, pend_set, restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev   <= 1'b1;
         sclk_prev <= 1'b0;
      end else begin
         cs_prev   <= cs_lvl_i;
         sclk_prev <= sclk_lvl_i;
      end
   end

   assign active    = ~cs_lvl_i;
   assign cs_fall   = cs_prev & ~cs_lvl_i;
   assign sclk_rise = active & sclk_lvl_i & ~sclk_prev;
   assign sclk_fall = active & ~sclk_lvl_i & sclk_prev;

   always_comb begin
      reload_now  = done_i && active &&
                    (((fall_cnt == HOLD_N) && (rise_cnt == HOLD_N)) || (fall_cnt == LONG_N));
      pend_set    = done_i && active && (rise_cnt > HOLD_N) && (fall_cnt < LONG_N);
      reload_late = pend_q && sclk_fall && (fall_cnt == LONG_N - 1'b1);
      restart     = cs_fall | reload_now | reload_late;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt <= '0;
         fall_cnt <= '0;
         addr_sh  <= '0;
         pend_q   <= 1'b0;
      end else if (restart) begin
         rise_cnt <= '0;
         fall_cnt <= '0;
         pend_q   <= 1'b0;
      end else begin
         if (pend_set) pend_q <= 1'b1;
         if (sclk_rise) begin
            if (rise_cnt < ADDR_LAST) addr_sh <= {addr_sh[ADDR_W-2:0], sdat_i};
            if (rise_cnt != LONG_N)   rise_cnt <= rise_cnt + 1'b1;
         end
         if (sclk_fall && (fall_cnt != LONG_N)) fall_cnt <= fall_cnt + 1'b1;
      end
   end

   assign active_o     = active;
   assign sclk_fall_o  = sclk_fall;
   assign load_o       = restart;
   assign start_o      = sclk_fall && !cs_fall && (fall_cnt == HOLD_N - 1'b1);
   assign addr_o       = addr_sh;
   assign sample_win_o = active && !cs_fall && (fall_cnt >= SAMP_LO) && (fall_cnt < HOLD_N);
   assign tail_zero_o  = fall_cnt >= HOLD_N;

   // R1
   idle_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(addr_sh));
   // R3
   addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_cnt >= ADDR_LAST) |=> $stable(addr_sh));
   // R6
   samp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sample_win_o) |-> $past(sclk_fall));
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
   parameter int unsigned RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [RES_W-1:0] load_val_i,
   input  logic             shift_i,
   input  logic             tail_zero_i,
   input  logic             en_i,
   output logic             sdo_o,
   output logic             sdo_en_o
);
   logic [RES_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (load_i)  sh_q <= load_val_i;
      else if (shift_i) sh_q <= {sh_q[RES_W-2:0], 1'b0};
   end

   assign sdo_o    = sh_q[RES_W-1] & ~tail_zero_i;
   assign sdo_en_o = en_i;
endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv
   import adc_serial_seq_pkg::*;
#(
   parameter int unsigned RES_W    = 10,
   parameter int unsigned CONV_CYC = 100,
   parameter int unsigned LAST_CH  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] chan_i,
   input  logic [RES_W-1:0]  data_i,
   output logic              eoc_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] chan_o,
   output logic [RES_W-1:0]  result_o
);
   localparam int unsigned TW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
   localparam logic [TW-1:0] LOAD_V = TW'(CONV_CYC - 1);

   logic [TW-1:0] tmr_q;
   logic          busy_q;
   logic          wild;

   assign wild = chan_o > ADDR_W'(LAST_CH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q    <= '0;
         busy_q   <= 1'b0;
         done_o   <= 1'b0;
         chan_o   <= '0;
         result_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            busy_q <= 1'b1;
            tmr_q  <= LOAD_V;
            chan_o <= chan_i;
         end else if (busy_q) begin
            if (tmr_q == '0) begin
               busy_q   <= 1'b0;
               done_o   <= 1'b1;
               result_o <= wild ? '0 : data_i;
            end else begin
               tmr_q <= tmr_q - 1'b1;
            end
         end
      end
   end

   assign eoc_o = ~busy_q;

   // R7
   eoc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eoc_o) |-> $past(start_i));
   // R7
   eoc_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_o) |-> done_o);
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
   import adc_serial_seq_pkg::*;
#(
   parameter int unsigned RES_W       = 10,
   parameter int unsigned CONV_CYC    = 100,
   parameter int unsigned LAST_CH     = 13,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              io_clk,
   input  logic              addr_sdi,
   input  logic [RES_W-1:0]  conv_data,
   output logic              sdo,
   output logic              sdo_en,
   output logic              eoc,
   output logic              sample_win,
   output logic [ADDR_W-1:0] conv_chan
);
   if (RES_W < HOLD_EDGE) begin : g_bad_res
      $error("adc_serial_seq: RES_W must cover the hold edge count");
   end
   if (CONV_CYC < 2) begin : g_bad_conv
      $error("adc_serial_seq: CONV_CYC must be at least 2");
   end
   if (LAST_CH >= (1 << ADDR_W)) begin : g_bad_ch
      $error("adc_serial_seq: LAST_CH exceeds the channel code range");
   end

   logic [2:0] pin_lvl;
   logic active, sclk_fall, load, start, done, tail_zero;
   logic [ADDR_W-1:0] addr;
   logic [RES_W-1:0]  result;

   adc_seq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .async_i({cs_n, io_clk, addr_sdi}),
      .lvl_o(pin_lvl)
   );

   adc_seq_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cs_lvl_i(pin_lvl[2]), .sclk_lvl_i(pin_lvl[1]), .sdat_i(pin_lvl[0]),
      .done_i(done),
      .active_o(active), .sclk_fall_o(sclk_fall), .load_o(load), .start_o(start),
      .addr_o(addr), .sample_win_o(sample_win), .tail_zero_o(tail_zero)
   );

   adc_seq_conv #(.RES_W(RES_W), .CONV_CYC(CONV_CYC), .LAST_CH(LAST_CH)) u_conv (
      .clk(clk), .rst_n(rst_n),
      .start_i(start), .chan_i(addr), .data_i(conv_data),
      .eoc_o(eoc), .done_o(done), .chan_o(conv_chan), .result_o(result)
   );

   adc_seq_shift #(.RES_W(RES_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .load_i(load), .load_val_i(result), .shift_i(sclk_fall),
      .tail_zero_i(tail_zero), .en_i(active),
      .sdo_o(sdo), .sdo_en_o(sdo_en)
   );

   // R5
   tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_zero && sdo_en) |-> !sdo);
   // R2
   reload_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sdo == $past(result[RES_W-1])));
endmodule

// File: tb/adc_serial_seq_tb.sv
module adc_serial_seq_tb;
   localparam int RES_W = 10;
   localparam int CONV_CYC = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, io_clk = 1'b0, addr_sdi = 1'b0;
   logic [RES_W-1:0] conv_data;
   logic sdo, sdo_en, eoc, sample_win;
   logic [3:0] conv_chan;

   always #4 clk = ~clk;

   function automatic logic [RES_W-1:0] chan_val(input logic [3:0] ch);
      return RES_W'((int'(ch) * 83 + 21) ^ 10'h2C9);
   endfunction
   function automatic logic [RES_W-1:0] model_res(input logic [3:0] ch);
      return (ch > 4'd13) ? '0 : chan_val(ch);
   endfunction

   assign conv_data = chan_val(conv_chan);

   adc_serial_seq #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk), .addr_sdi(addr_sdi),
      .conv_data(conv_data), .sdo(sdo), .sdo_en(sdo_en), .eoc(eoc),
      .sample_win(sample_win), .conv_chan(conv_chan)
   );

   typedef struct packed { logic [3:0] kind; logic [15:0] exp; } item_t;
   item_t q_item[$];
   string q_tag[$];
   event  smp_ev;
   int n_vec = 0, n_bad = 0;
   int run_low = 0, last_low = 0;
   bit finished = 0;

   always @(negedge clk) begin
      if (eoc === 1'b0) run_low++;
      else if (run_low > 0) begin last_low = run_low; run_low = 0; end
   end

   // monitor: pops expected items and compares them with the outputs
   always begin
      @(smp_ev);
      while (q_item.size() > 0) begin
         item_t it;
         string tg;
         logic [15:0] act;
         it = q_item.pop_front();
         tg = q_tag.pop_front();
         case (it.kind)
            4'd0: act = {15'd0, sdo};
            4'd1: act = {15'd0, sdo_en};
            4'd2: act = {15'd0, eoc};
            4'd3: act = {12'd0, conv_chan};
            4'd4: act = {15'd0, sample_win};
            default: act = 16'(last_low);
         endcase
         n_vec++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s kind=%0d actual=%0h expected=%0h", tg, it.kind, act, it.exp);
         end
      end
   end

   task automatic expect_v(input int kind, input int val, input string tg);
      item_t it;
      it.kind = 4'(kind);
      it.exp  = 16'(val);
      q_item.push_back(it);
      q_tag.push_back(tg);
      -> smp_ev;
   endtask

   task automatic wait_clk(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wait_eoc();
      while (eoc !== 1'b1) @(negedge clk);
   endtask

   // driver: one transfer of nclk serial clocks with half period h
   task automatic xfer(input logic [3:0] ch, input int nclk, input int h,
                       input logic [RES_W-1:0] prv, input logic [RES_W-1:0] nxt,
                       input bit rel16);
      wait_clk(4);
      expect_v(1, 1, "R2 sdo_en");
      expect_v(0, prv[RES_W-1], "R2 msb");
      for (int i = 1; i <= nclk; i++) begin
         addr_sdi = (i <= 4) ? ch[4-i] : i[0];
         wait_clk(h);
         io_clk = 1'b1;
         wait_clk(h);
         io_clk = 1'b0;
         wait_clk(4);
         if (i <= 9)                    expect_v(0, prv[RES_W-1-i], "R4 bit");
         else if (i == nclk && rel16)   expect_v(0, nxt[RES_W-1], "R10 msb at 16th");
         else                           expect_v(0, 0, "R5 tail");
         if (i <= 10) expect_v(4, (i >= 4 && i <= 9) ? 1 : 0, "R6 window");
         if (i == 10) begin
            expect_v(2, 0, "R7 eoc low");
            expect_v(3, ch, "R3 chan");
         end
      end
   endtask

   initial begin
      logic [RES_W-1:0] prev;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      expect_v(1, 0, "R1 reset sdo_en");
      expect_v(2, 1, "R7 reset eoc");
      expect_v(3, 0, "R3 reset chan");

      // R1: activity while deselected is ignored
      for (int i = 0; i < 10; i++) begin
         addr_sdi = 1'b1; io_clk = 1'b1; wait_clk(5);
         io_clk = 1'b0; wait_clk(5);
      end
      wait_clk(6);
      expect_v(2, 1, "R1 eoc idle");
      expect_v(3, 0, "R1 chan idle");
      expect_v(1, 0, "R1 sdo_en idle");
      prev = '0;

      // select released between transfers, 10 clocks
      cs_n = 1'b0;
      xfer(4'd5, 10, 5, prev, '0, 0);
      cs_n = 1'b1;
      wait_clk(4);
      expect_v(1, 0, "R1 sdo_en off");
      wait_eoc(); wait_clk(2);
      expect_v(5, CONV_CYC, "R7 conv length");
      prev = model_res(4'd5);

      // select released, 14 clocks
      cs_n = 1'b0;
      xfer(4'd13, 14, 5, prev, '0, 0);
      cs_n = 1'b1;
      wait_eoc(); wait_clk(2);
      prev = model_res(4'd13);

      // out-of-range channel
      cs_n = 1'b0;
      xfer(4'd14, 10, 5, prev, '0, 0);
      cs_n = 1'b1;
      wait_eoc(); wait_clk(2);
      prev = model_res(4'd14);
      cs_n = 1'b0;
      wait_clk(4);
      expect_v(0, 0, "R8 zero result msb");

      // select held low, 10 clocks
      xfer(4'd2, 10, 5, prev, '0, 0);
      wait_eoc(); wait_clk(3);
      prev = model_res(4'd2);
      expect_v(0, prev[RES_W-1], "R9 msb on eoc rise");
      xfer(4'd7, 10, 5, prev, '0, 0);
      wait_eoc(); wait_clk(3);
      prev = model_res(4'd7);
      expect_v(0, prev[RES_W-1], "R9 msb on eoc rise");

      // select held low, fast 16 clocks
      xfer(4'd3, 16, 5, prev, '0, 0);
      wait_eoc(); wait_clk(3);
      prev = model_res(4'd3);
      expect_v(0, prev[RES_W-1], "R9 msb after 16 fast");
      expect_v(5, CONV_CYC, "R7 conv length");

      // select held low, slow 16 clocks
      xfer(4'd11, 16, 20, prev, model_res(4'd11), 1);
      prev = model_res(4'd11);
      xfer(4'd9, 16, 20, prev, model_res(4'd9), 1);
      prev = model_res(4'd9);
      cs_n = 1'b1;
      wait_clk(4);
      expect_v(1, 0, "R1 sdo_en final");

      wait_clk(2);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 150000; k++) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule